// File: doc/BRIEF.md
# Operand Register Attribute Lookup

This block sits beside an instruction decoder. For each operand register number the decoder presents, it returns the element width code and the vector length to use for that operand. A small table of programmable slots holds the attributes. In the default build, each slot carries a register tag, a width code, a length and a valid flag. Every lookup compares the queried register number against all slots at once. The lowest-numbered valid slot whose tag matches supplies the result.

When no slot matches, the register is treated as a scalar. The width is then the default that the decoder drives for the current opcode, and the length is one. A build-time parameter swaps the tag search for direct indexing. In that mode there is one slot per register number, the queried register number selects its own slot, and the written tag is ignored.

The lookup path is purely combinational. A single write port programs one slot per cycle. Each write loads the slot's valid flag, tag, width code and length, and the new contents take effect from the following cycle.

Top module: `reg_attr_lookup`

## Requirements
- R1: After a synchronous active-low reset, every slot is invalid. Every lookup then returns `lk_hit`=0, `lk_slot`=0, `lk_len`=1, and `lk_width` equal to `lk_dflt_width`.
- R2: In the same cycle as the query, a valid slot whose tag equals `lk_reg` drives `lk_hit`=1, `lk_slot` equal to that slot's index, and that slot's stored width code and length on `lk_width` and `lk_len`.
- R3: When several valid slots match the query, the one with the smallest index supplies the result.
- R4: A slot written with `wr_valid`=0 never matches, whatever tag it holds.
- R5: With no matching slot, `lk_hit`=0, `lk_slot`=0, `lk_len`=1 and `lk_width` equals `lk_dflt_width` in the same cycle.
- R6: A write with `wr_en`=1 loads the slot numbered `wr_slot` at the next rising edge. A lookup in the cycle of the write still returns the slot's previous contents.
- R7: While `wr_en`=0, no slot's contents change. This holds whatever values the other write inputs carry.
- R8: With `LOOKUP_MODE`=MODE_DIRECT, there are 2^`REG_W` slots. Slot k answers only the query `lk_reg`=k, and the written `wr_reg` has no effect on matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_slot | input | SLOT_W | Slot index to write |
| wr_valid | input | 1 | Valid flag to store |
| wr_reg | input | REG_W | Register tag to store (unused in direct mode) |
| wr_width | input | WCODE_W | Width code to store |
| wr_len | input | LEN_W | Vector length to store |
| lk_reg | input | REG_W | Queried operand register number |
| lk_dflt_width | input | WCODE_W | Opcode default width code |
| lk_hit | output | 1 | A slot matched |
| lk_slot | output | SLOT_W | Index of the winning slot, 0 on a miss |
| lk_width | output | WCODE_W | Resolved width code |
| lk_len | output | LEN_W | Resolved vector length |

## Verification
A slot can be rewritten in the same cycle that a query reads it. In that cycle the lookup must still report the slot's old contents, and the new contents must appear only after the edge. The bench provokes this both by directed cases and by random traffic. Random queries are confined to a few register numbers, so writes and queries often hit the same slot. The bench checks the outputs before the edge against its pre-write model, then moves the model forward.

// File: rtl/reg_attr_pkg.sv
// Package: shared types for the operand register attribute lookup.
// Assumes: nothing beyond IEEE 1800-2017.
package reg_attr_pkg;

    // Selects how a queried register number finds its slot.
    typedef enum logic {
        MODE_ASSOC  = 1'b0,   // tag compare across all slots, lowest index wins
        MODE_DIRECT = 1'b1    // register number is the slot index
    } lookup_mode_e;

endpackage

// File: rtl/reg_attr_slot.sv
// Module: one attribute slot. Stores valid, tag, width code and length, and
// raises a match flag when the stored attributes apply to the queried register.
// Assumes: the writer addresses at most one slot per cycle; in direct mode
// the slot identity stands in for the tag.
module reg_attr_slot
    import reg_attr_pkg::*;
#(
    parameter int           REG_W   = 5,
    parameter int           WCODE_W = 2,
    parameter int           LEN_W   = 5,
    parameter int           SLOT_W  = 1,
    parameter int           SLOT_ID = 0,
    parameter lookup_mode_e MODE    = MODE_ASSOC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SLOT_W-1:0]  wr_slot,
    input  logic               wr_valid,
    input  logic [REG_W-1:0]   wr_reg,
    input  logic [WCODE_W-1:0] wr_width,
    input  logic [LEN_W-1:0]   wr_len,
    input  logic [REG_W-1:0]   lk_reg,
    output logic               match,
    output logic [WCODE_W-1:0] width,
    output logic [LEN_W-1:0]   len
);

    logic               sel;
    logic               valid_q;
    logic [WCODE_W-1:0] width_q;
    logic [LEN_W-1:0]   len_q;

    // Decode whether this cycle's write addresses this slot.
    assign sel = wr_en && (wr_slot == SLOT_W'(SLOT_ID));

    // Hold the valid flag and the attribute fields; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            width_q <= '0;
            len_q   <= '0;
        end else if (sel) begin
            valid_q <= wr_valid;
            width_q <= wr_width;
            len_q   <= wr_len;
        end
    end

    assign width = width_q;
    assign len   = len_q;

    generate
        if (MODE == MODE_ASSOC) begin : g_tag
            logic [REG_W-1:0] tag_q;

            // Hold the register tag this slot answers to.
            always_ff @(posedge clk) begin
                if (!rst_n)   tag_q <= '0;
                else if (sel) tag_q <= wr_reg;
            end

            // Match on a valid slot whose tag equals the query.
            assign match = valid_q && (tag_q == lk_reg);
        end else begin : g_direct
            logic unused_tag;
            assign unused_tag = ^wr_reg;

            // Match on a valid slot whose own index equals the query.
            assign match = valid_q && (lk_reg == REG_W'(SLOT_ID));
        end
    endgenerate

    // R6
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel |=> (valid_q == $past(wr_valid)) && (width_q == $past(wr_width))
                && (len_q == $past(wr_len)));

    // R7
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(valid_q) && $stable(width_q) && $stable(len_q));

endmodule

// File: rtl/reg_attr_pick.sv
// Module: first-match picker. Given per-slot match flags and attributes,
// returns the attributes of the lowest matching slot, or the default width
// with a length of one when nothing matches.
// Assumes: clk and rst_n are used by the embedded assertions only.
module reg_attr_pick #(
    parameter int N       = 2,
    parameter int SLOT_W  = 1,
    parameter int WCODE_W = 2,
    parameter int LEN_W   = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         match_vec,
    input  logic [N*WCODE_W-1:0] width_flat,
    input  logic [N*LEN_W-1:0]   len_flat,
    input  logic [WCODE_W-1:0]   dflt_width,
    output logic                 hit,
    output logic [SLOT_W-1:0]    slot,
    output logic [WCODE_W-1:0]   width,
    output logic [LEN_W-1:0]     len
);

    // Scan from the top slot downward so the lowest match is the last one written.
    always_comb begin
        hit   = 1'b0;
        slot  = '0;
        width = dflt_width;
        len   = LEN_W'(1);
        for (int i = N - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit   = 1'b1;
                slot  = SLOT_W'(i);
                width = width_flat[i*WCODE_W +: WCODE_W];
                len   = len_flat[i*LEN_W +: LEN_W];
            end
        end
    end

    logic [N-1:0] below_mask;
    // Mask of slots with a smaller index than the reported winner.
    assign below_mask = (N'(1) << slot) - N'(1);

    // R3
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> match_vec[slot] && ((match_vec & below_mask) == '0));

endmodule

// File: rtl/reg_attr_lookup.sv
// Module: top of the operand register attribute lookup. Instantiates the slot
// array (tag-searched or directly indexed) and the first-match picker.
// Assumes: combinational lookup; writes take effect at the next edge.
module reg_attr_lookup
    import reg_attr_pkg::*;
#(
    parameter int           NUM_SLOTS   = 2,
    parameter int           REG_W       = 5,
    parameter int           WCODE_W     = 2,
    parameter int           LEN_W       = 5,
    parameter lookup_mode_e LOOKUP_MODE = MODE_ASSOC,
    localparam int          N_SLOTS     = (LOOKUP_MODE == MODE_DIRECT) ? (1 << REG_W) : NUM_SLOTS,
    localparam int          SLOT_W      = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SLOT_W-1:0]  wr_slot,
    input  logic               wr_valid,
    input  logic [REG_W-1:0]   wr_reg,
    input  logic [WCODE_W-1:0] wr_width,
    input  logic [LEN_W-1:0]   wr_len,
    input  logic [REG_W-1:0]   lk_reg,
    input  logic [WCODE_W-1:0] lk_dflt_width,
    output logic               lk_hit,
    output logic [SLOT_W-1:0]  lk_slot,
    output logic [WCODE_W-1:0] lk_width,
    output logic [LEN_W-1:0]   lk_len
);

    logic [N_SLOTS-1:0]         match_vec;
    logic [N_SLOTS*WCODE_W-1:0] width_flat;
    logic [N_SLOTS*LEN_W-1:0]   len_flat;

    // One storage slot per table entry.
    generate
        for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
            reg_attr_slot #(
                .REG_W   (REG_W),
                .WCODE_W (WCODE_W),
                .LEN_W   (LEN_W),
                .SLOT_W  (SLOT_W),
                .SLOT_ID (s),
                .MODE    (LOOKUP_MODE)
            ) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (wr_en),
                .wr_slot  (wr_slot),
                .wr_valid (wr_valid),
                .wr_reg   (wr_reg),
                .wr_width (wr_width),
                .wr_len   (wr_len),
                .lk_reg   (lk_reg),
                .match    (match_vec[s]),
                .width    (width_flat[s*WCODE_W +: WCODE_W]),
                .len      (len_flat[s*LEN_W +: LEN_W])
            );
        end
    endgenerate

    // Resolve the winning slot or fall back to scalar defaults.
    reg_attr_pick #(
        .N       (N_SLOTS),
        .SLOT_W  (SLOT_W),
        .WCODE_W (WCODE_W),
        .LEN_W   (LEN_W)
    ) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .match_vec  (match_vec),
        .width_flat (width_flat),
        .len_flat   (len_flat),
        .dflt_width (lk_dflt_width),
        .hit        (lk_hit),
        .slot       (lk_slot),
        .width      (lk_width),
        .len        (lk_len)
    );

    // R5
    scalar_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_len == LEN_W'(1)) && (lk_width == lk_dflt_width)
                    && (lk_slot == '0));

endmodule

// File: tb/tb_reg_attr_lookup.sv
module tb_reg_attr_lookup;
    import reg_attr_pkg::*;

    localparam int REG_W = 5, WCODE_W = 2, LEN_W = 5, NS = 2;
    localparam int DS = 1 << REG_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int n_vec = 0, n_bad = 0;
    bit done = 1'b0;

    // associative instance
    logic               wr_en = 0, wr_valid = 0;
    logic [0:0]         wr_slot = 0;
    logic [REG_W-1:0]   wr_reg = 0, lk_reg = 0;
    logic [WCODE_W-1:0] wr_width = 0, lk_dflt = 0, lk_width;
    logic [LEN_W-1:0]   wr_len = 0, lk_len;
    logic               lk_hit;
    logic [0:0]         lk_slot;

    reg_attr_lookup #(.NUM_SLOTS(NS), .REG_W(REG_W), .WCODE_W(WCODE_W),
                      .LEN_W(LEN_W), .LOOKUP_MODE(MODE_ASSOC)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
        .wr_valid(wr_valid), .wr_reg(wr_reg), .wr_width(wr_width),
        .wr_len(wr_len), .lk_reg(lk_reg), .lk_dflt_width(lk_dflt),
        .lk_hit(lk_hit), .lk_slot(lk_slot), .lk_width(lk_width), .lk_len(lk_len));

    // direct-indexed instance
    logic               d_wr_en = 0, d_wr_valid = 0;
    logic [REG_W-1:0]   d_wr_slot = 0, d_wr_reg = 0, d_lk_reg = 0, d_lk_slot;
    logic [WCODE_W-1:0] d_wr_width = 0, d_lk_dflt = 0, d_lk_width;
    logic [LEN_W-1:0]   d_wr_len = 0, d_lk_len;
    logic               d_lk_hit;

    reg_attr_lookup #(.NUM_SLOTS(NS), .REG_W(REG_W), .WCODE_W(WCODE_W),
                      .LEN_W(LEN_W), .LOOKUP_MODE(MODE_DIRECT)) dut_direct (
        .clk(clk), .rst_n(rst_n), .wr_en(d_wr_en), .wr_slot(d_wr_slot),
        .wr_valid(d_wr_valid), .wr_reg(d_wr_reg), .wr_width(d_wr_width),
        .wr_len(d_wr_len), .lk_reg(d_lk_reg), .lk_dflt_width(d_lk_dflt),
        .lk_hit(d_lk_hit), .lk_slot(d_lk_slot), .lk_width(d_lk_width), .lk_len(d_lk_len));

    // reference model of the associative table
    bit               m_v [NS];
    logic [REG_W-1:0] m_r [NS];
    logic [WCODE_W-1:0] m_w [NS];
    logic [LEN_W-1:0] m_l [NS];

    // expected {hit, slot, width, len} per the requirements
    function automatic logic [1+1+WCODE_W+LEN_W-1:0] expect_assoc(
            logic [REG_W-1:0] q, logic [WCODE_W-1:0] d);
        for (int i = 0; i < NS; i++)
            if (m_v[i] && m_r[i] == q) return {1'b1, 1'(i), m_w[i], m_l[i]};
        return {1'b0, 1'b0, d, LEN_W'(1)};
    endfunction

    task automatic check_assoc(string req);
        logic [1+1+WCODE_W+LEN_W-1:0] e, a;
        e = expect_assoc(lk_reg, lk_dflt);
        a = {lk_hit, lk_slot, lk_width, lk_len};
        n_vec++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s: reg=%0d actual=%h expected=%h", req, lk_reg, a, e);
        end
    endtask

    // one cycle: drive at negedge, check before posedge, then advance model
    task automatic cyc(logic we, logic [0:0] ws, logic wv, logic [REG_W-1:0] wrg,
                       logic [WCODE_W-1:0] ww, logic [LEN_W-1:0] wl,
                       logic [REG_W-1:0] q, logic [WCODE_W-1:0] d, string req);
        @(negedge clk);
        wr_en = we; wr_slot = ws; wr_valid = wv; wr_reg = wrg;
        wr_width = ww; wr_len = wl; lk_reg = q; lk_dflt = d;
        #1;
        check_assoc(req);
        @(posedge clk);
        if (we) begin
            m_v[ws] = wv; m_r[ws] = wrg; m_w[ws] = ww; m_l[ws] = wl;
        end
    endtask

    task automatic check_direct(logic exp_hit, logic [REG_W-1:0] exp_slot,
                                logic [WCODE_W-1:0] exp_w, logic [LEN_W-1:0] exp_l, string req);
        logic [1+REG_W+WCODE_W+LEN_W-1:0] e, a;
        e = {exp_hit, exp_slot, exp_w, exp_l};
        a = {d_lk_hit, d_lk_slot, d_lk_width, d_lk_len};
        n_vec++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s: reg=%0d actual=%h expected=%h", req, d_lk_reg, a, e);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NS; i++) begin
            m_v[i] = 0; m_r[i] = 0; m_w[i] = 0; m_l[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state, several queries all miss
        cyc(0, 0, 0, 0, 0, 0, 5'd0, 2'd2, "R1");
        cyc(0, 0, 0, 0, 0, 0, 5'd31, 2'd1, "R1");
        // R2, R6: write slot 1 for r4; same-cycle query still misses
        cyc(1, 1, 1, 5'd4, 2'd3, 5'd8, 5'd4, 2'd0, "R6");
        cyc(0, 0, 0, 0, 0, 0, 5'd4, 2'd0, "R2");
        // R5: unmatched register returns default and length 1
        cyc(0, 0, 0, 0, 0, 0, 5'd5, 2'd3, "R5");
        // R3: both slots tag r4, slot 0 wins
        cyc(1, 0, 1, 5'd4, 2'd1, 5'd17, 5'd4, 2'd0, "R6");
        cyc(0, 0, 0, 0, 0, 0, 5'd4, 2'd2, "R3");
        // R4: invalidate slot 0, slot 1 answers; then invalid slot with new tag
        cyc(1, 0, 0, 5'd4, 2'd2, 5'd9, 5'd4, 2'd0, "R4");
        cyc(0, 0, 0, 0, 0, 0, 5'd4, 2'd0, "R4");
        cyc(1, 1, 0, 5'd9, 2'd2, 5'd3, 5'd9, 2'd1, "R4");
        cyc(0, 0, 0, 0, 0, 0, 5'd9, 2'd1, "R4");
        // R7: write inputs busy but strobe low
        cyc(0, 1, 1, 5'd9, 2'd3, 5'd31, 5'd9, 2'd1, "R7");
        cyc(0, 0, 0, 0, 0, 0, 5'd9, 2'd1, "R7");
        // R2: zero length is returned as stored
        cyc(1, 0, 1, 5'd0, 2'd3, 5'd0, 5'd0, 2'd1, "R6");
        cyc(0, 0, 0, 0, 0, 0, 5'd0, 2'd1, "R2");

        // random traffic on a narrow register range to force collisions
        for (int k = 0; k < 2000; k++) begin
            logic we;
            we = ($urandom % 3) == 0;
            cyc(we, 1'($urandom), ($urandom % 4) != 0, REG_W'($urandom % 4),
                WCODE_W'($urandom), LEN_W'($urandom), REG_W'($urandom % 5),
                WCODE_W'($urandom), we ? "R6" : "R2");
        end

        // R8: direct mode, slot 7 written with an unrelated tag
        @(negedge clk);
        d_wr_en = 1; d_wr_slot = 5'd7; d_wr_valid = 1; d_wr_reg = 5'd3;
        d_wr_width = 2'd2; d_wr_len = 5'd12; d_lk_reg = 5'd7; d_lk_dflt = 2'd1;
        #1 check_direct(0, 5'd0, 2'd1, 5'd1, "R8");
        @(negedge clk);
        d_wr_en = 0;
        #1 check_direct(1, 5'd7, 2'd2, 5'd12, "R8");
        d_lk_reg = 5'd3; d_lk_dflt = 2'd0;
        #1 check_direct(0, 5'd0, 2'd0, 5'd1, "R8");
        @(negedge clk);
        d_wr_en = 1; d_wr_slot = 5'd31; d_wr_valid = 1; d_wr_reg = 5'd7;
        d_wr_width = 2'd3; d_wr_len = 5'd30; d_lk_reg = 5'd31;
        @(negedge clk);
        d_wr_en = 0;
        #1 check_direct(1, 5'd31, 2'd3, 5'd30, "R8");
        d_lk_reg = 5'd7;
        #1 check_direct(1, 5'd7, 2'd2, 5'd12, "R8");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule